// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block generates addresses for a synchronous SRAM port that runs four-beat bursts. On every clock edge where standby is not requested, the advance control selects one of two actions. With advance low, the block captures a full external address as the first beat of a new burst. With advance high, it steps an internal two-bit beat counter and drives the address for that step. The upper address bits keep their loaded value for the whole burst. The two lowest bits follow one of two orders, chosen by a strap input. Linear order adds the beat count to the loaded low bits, modulo 4. Interleaved order XORs the beat count into the loaded low bits. In both orders the low bits return to the loaded value after four beats.

A sleep input holds the block in standby. While it is high, the address and the beat counter are frozen and every command is ignored. The beat index goes out beside the address, so a consumer can tell which beat of the burst is being driven.

Control comes from a small state machine with three states:
- `ST_IDLE`: the state after reset, before any burst has been loaded.
- `ST_BURST`: a burst is loaded and can be stepped.
- `ST_DOZE`: standby while a burst is held.

Transitions:
- T_LOAD goes from any state to `ST_BURST` when sleep is low and advance is low.
- T_STEP stays in `ST_BURST`, or goes from `ST_DOZE` to `ST_BURST`, when sleep is low and advance is high.
- T_NAP goes from `ST_BURST` to `ST_DOZE` when sleep is high.
- T_HOLD keeps `ST_DOZE` in place, or keeps `ST_IDLE` in place, while sleep is high.
- T_WAIT keeps `ST_IDLE` in place when sleep is low and advance is high.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst high on a clock edge) clears the state to `ST_IDLE`. After the edge, addr_out is 0 and beat is 0.
- R2: On an edge with sleep=0 and adv=0, the block loads from any state, including partway through a burst. After the edge, addr_out equals addr_in and beat is 0.
- R3: On an edge with sleep=0 and adv=1 while a burst is loaded, beat becomes (beat+1) mod 4. Bits addr_out[AW-1:2] keep their loaded value.
- R4: With order_sel=0 (linear), addr_out[1:0] equals (L + beat) mod 4, where L is the loaded value of bits [1:0]. Starting from L=01, for example, the beats give 01, 10, 11, 00.
- R5: With order_sel=1 (interleaved), addr_out[1:0] equals L XOR beat. Starting from L=01, the beats give 01, 00, 11, 10. Starting from L=10, they give 10, 11, 00, 01.
- R6: A fourth advance after a load wraps beat to 0, and addr_out[1:0] to L. A fifth advance repeats the second address.
- R7: While sleep=1, beat and addr_out[AW-1:2] hold their values, and adv is ignored whether it is 0 or 1.
- R8: Once sleep returns to 0, adv=1 continues the held burst from the held beat, and adv=0 starts a fresh burst at beat 0.
- R9: In `ST_IDLE`, adv=1 with sleep=0 is ignored: addr_out stays 0 and beat stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | 1 = step the burst; 0 = load addr_in |
| sleep | input | 1 | 1 = standby, all commands ignored |
| order_sel | input | 1 | Burst order strap: 0 = linear, 1 = interleaved |
| addr_in | input | AW | External start address, captured on a load |
| addr_out | output | AW | Address of the current access |
| beat | output | 2 | Beat index 0 to 3 within the burst |

## Verification
Two cases are the hardest to reach from the ports. The first is a sleep period that starts partway through a burst and then ends with an advance. It must resume from the held beat, not restart. The second is a load that lands partway through a burst. Random stimulus gives sleep and load a fair weight, so both cases keep recurring at every beat position. Directed bursts cover all four start values in both orders, run through the wrap and one beat past it, and include an advance issued before any load has been made.

// File: rtl/bag_pkg.sv
package bag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DOZE  = 2'd2
    } bag_state_e;

    localparam int BEAT_W = 2;

endpackage

// File: rtl/bag_ctrl.sv
module bag_ctrl
    import bag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       sleep,
    output bag_state_e state_q,
    output logic       do_load,
    output logic       do_step
);

    bag_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!sleep && !adv) state_d = ST_BURST;  // T_LOAD
                else                state_d = ST_IDLE;   // T_HOLD / T_WAIT
            end
            ST_BURST: begin
                if (sleep) state_d = ST_DOZE;            // T_NAP
                else       state_d = ST_BURST;           // T_LOAD / T_STEP
            end
            ST_DOZE: begin
                if (sleep) state_d = ST_DOZE;            // T_HOLD
                else       state_d = ST_BURST;           // T_LOAD / T_STEP
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output decode
    always_comb begin
        do_load = 1'b0;
        do_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                do_load = !sleep && !adv;
            end
            ST_BURST, ST_DOZE: begin
                do_load = !sleep && !adv;
                do_step = !sleep &&  adv;
            end
            default: begin
                do_load = 1'b0;
                do_step = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bag_regs.sv
module bag_regs
    import bag_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              do_load,
    input  logic              do_step,
    input  logic [AW-1:0]     addr_in,
    output logic [AW-1:0]     base_q,
    output logic [BEAT_W-1:0] beat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (do_load) begin
            base_q <= addr_in;
            beat_q <= '0;
        end else if (do_step) begin
            beat_q <= beat_q + 1'b1;
        end
    end

endmodule

// File: rtl/bag_order.sv
module bag_order
    import bag_pkg::*;
(
    input  logic              order_sel,
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] addr_lo
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    assign lin_lo = start_lo + beat;

    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_lo[i] = start_lo[i] ^ beat[i];
    end

    assign addr_lo = order_sel ? ilv_lo : lin_lo;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              sleep,
    input  logic              order_sel,
    input  logic [AW-1:0]     addr_in,
    output logic [AW-1:0]     addr_out,
    output logic [BEAT_W-1:0] beat
);

    bag_state_e        state_q;
    logic              do_load;
    logic              do_step;
    logic [AW-1:0]     base_q;
    logic [BEAT_W-1:0] addr_lo;

    bag_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .sleep   (sleep),
        .state_q (state_q),
        .do_load (do_load),
        .do_step (do_step)
    );

    bag_regs #(.AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .do_load (do_load),
        .do_step (do_step),
        .addr_in (addr_in),
        .base_q  (base_q),
        .beat_q  (beat)
    );

    bag_order u_order (
        .order_sel (order_sel),
        .start_lo  (base_q[BEAT_W-1:0]),
        .beat      (beat),
        .addr_lo   (addr_lo)
    );

    assign addr_out = {base_q[AW-1:BEAT_W], addr_lo};

endmodule

// File: rtl/bag_checker.sv
module bag_checker
    import bag_pkg::*;
#(
    parameter int AW = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              adv,
    input logic              sleep,
    input logic [AW-1:0]     addr_in,
    input logic [AW-1:0]     addr_out,
    input logic [BEAT_W-1:0] beat,
    input bag_state_e        state_q
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    assert_reset_R1: assert property (@(posedge clk) disable iff (!armed)
        ($past(rst) && !rst) |-> (addr_out == '0 && beat == '0 && state_q == ST_IDLE));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(rst) && !$past(sleep) && !$past(adv))
        |-> (addr_out == $past(addr_in) && beat == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(rst) && !$past(sleep) && $past(adv) && $past(state_q) != ST_IDLE)
        |-> (beat == $past(beat) + 2'd1 && $stable(addr_out[AW-1:BEAT_W])));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(rst) && $past(sleep))
        |-> ($stable(beat) && $stable(addr_out[AW-1:BEAT_W])));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(rst) && $past(state_q) == ST_IDLE && $past(adv))
        |-> (state_q == ST_IDLE && beat == '0 && addr_out == '0));

endmodule

bind burst_addr_gen bag_checker #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .sleep    (sleep),
    .addr_in  (addr_in),
    .addr_out (addr_out),
    .beat     (beat),
    .state_q  (state_q)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          adv = 1'b0;
    logic          sleep = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    bit            m_loaded = 1'b0;

    burst_addr_gen #(.AW(AW)) i_burst_addr_gen (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .sleep     (sleep),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .addr_out  (addr_out),
        .beat      (beat)
    );

    always #4 clk = ~clk;

    function automatic logic [1:0] lo_of(input logic [1:0] s, input logic [1:0] b,
                                         input logic mode);
        return mode ? (s ^ b) : 2'(s + b);
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        return {m_base[AW-1:2], lo_of(m_base[1:0], m_beat, order_sel)};
    endfunction

    task automatic check(input string req, input logic [AW-1:0] a_exp,
                         input logic [1:0] b_exp);
        n_tests++;
        if (addr_out !== a_exp || beat !== b_exp) begin
            n_fail++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, addr_out, beat, a_exp, b_exp);
        end
    endtask

    // apply the edge just taken to the model, then check; returns tag
    task automatic step_and_check();
        string tag;
        @(negedge clk);
        if (rst) begin
            m_base = '0; m_beat = '0; m_loaded = 0; tag = "R1";
        end else if (sleep) begin
            tag = "R7";
        end else if (!adv) begin
            m_base = addr_in; m_beat = '0; m_loaded = 1; tag = "R2";
        end else if (m_loaded) begin
            m_beat = m_beat + 2'd1; tag = order_sel ? "R5" : "R4";
        end else begin
            tag = "R9";
        end
        check(tag, exp_addr(), m_beat);
    endtask

    task automatic drive(input logic r, input logic a, input logic s,
                         input logic [AW-1:0] ad);
        rst = r; adv = a; sleep = s; addr_in = ad;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [AW-1:0] st;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        drive(1, 0, 0, 20'hABCDE);
        step_and_check();                       // R1 reset state
        // R9: advance before any load is ignored
        drive(0, 1, 0, 20'h12345);
        step_and_check();
        step_and_check();

        // directed: every start value, both orders, through the wrap (R4 R5 R6 R3)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                order_sel = m[0];
                st = {18'h2A5C3, 2'(s)};
                drive(0, 0, 0, st);
                step_and_check();
                drive(0, 1, 0, 20'h0);
                for (int k = 1; k <= 5; k++) begin
                    step_and_check();
                    n_tests++;
                    if (addr_out[AW-1:2] !== st[AW-1:2]) begin
                        n_fail++;
                        $display("FAIL R3: upper=%h expected %h", addr_out[AW-1:2], st[AW-1:2]);
                    end
                    if (k == 4) begin
                        n_tests++;
                        if (addr_out !== st || beat !== 2'd0) begin
                            n_fail++;
                            $display("FAIL R6: addr=%h beat=%0d expected addr=%h beat=0",
                                     addr_out, beat, st);
                        end
                    end
                end
            end
        end

        // directed R8: sleep partway, resume by advance, then load after sleep
        order_sel = 1'b0;
        drive(0, 0, 0, 20'h00011);
        step_and_check();
        drive(0, 1, 0, 20'h0);
        step_and_check();                       // beat 1
        drive(0, 1, 1, 20'h0);
        step_and_check();
        drive(0, 0, 1, 20'hFFFFF);
        step_and_check();                       // R7 load ignored
        drive(0, 1, 0, 20'h0);
        step_and_check();
        n_tests++;
        if (beat !== 2'd2 || addr_out !== 20'h00013) begin
            n_fail++;
            $display("FAIL R8: resume addr=%h beat=%0d expected addr=00013 beat=2", addr_out, beat);
        end
        drive(0, 1, 1, 20'h0);
        step_and_check();
        drive(0, 0, 0, 20'h00402);
        step_and_check();
        n_tests++;
        if (beat !== 2'd0 || addr_out !== 20'h00402) begin
            n_fail++;
            $display("FAIL R8: fresh addr=%h beat=%0d expected addr=00402 beat=0", addr_out, beat);
        end

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            rst = (r < 8'd3);
            sleep = (r[7:5] == 3'd7);
            adv = (r[4:2] != 3'd0);
            addr_in = AW'($urandom);
            if (r[1:0] == 2'b11 && r[7:6] == 2'b00) order_sel = ~order_sel;
            step_and_check();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule